// File: doc/BRIEF.md
# SDRAM Periodic Refresh Scheduler

This block keeps the contents of a four-bank SDRAM alive. Every row has to be refreshed within a 64 ms window, and the array has 8192 rows. That works out to one refresh about every 7.8 µs. A free-running interval counter sets the refresh rate. Its period is derived from the clock frequency in MHz and the target refresh period in ns, minus a small safety margin. The counter stays at zero until the memory has finished its power-up sequence. Each expiry of the counter adds one unit to a saturating pending count. While that count is non-zero and the block does not hold the command bus, it raises a refresh request.

The access sequencer answers the request with a grant once it is idle. The scheduler then owns the command bus. It first closes every bank with a precharge-all command and waits tRP. It then issues a run of AUTO REFRESH commands, each followed by a tRC wait, and drives NOP in every wait cycle. The length of the run is the pending count captured at the grant, multiplied by a refreshes-per-expiry factor. After the last tRC wait it releases the bus so that the sequencer can issue its next ACTIVE. Expiries that occur during a refresh event are held for the next event.

Top module: `sdram_refresh_sched`

## Requirements
- R1: While rst_ni is low the block drives req_o=0, own_o=0, cmd_o=NOP (3'b111), a10_o=0 and ba_o=0.
- R2: While init_done_i is low the interval counter stays at zero, so no request is raised. Once init_done_i is high, the first expiry lands on the INTERVAL_CYC-th rising edge, and req_o is high after that edge.
- R3: req_o is high exactly when the pending count is non-zero and own_o is low. It stays high until a grant is taken.
- R4: A grant is taken when grant_i is high at a rising edge where req_o is high. In the next cycle own_o=1 and cmd_o=PRECHARGE (3'b010), with a10_o=1 and ba_o=0. a10_o is high in no other cycle.
- R5: The first AUTO REFRESH (cmd_o=3'b001) appears T_RP cycles after the precharge. cmd_o is NOP in every cycle between them.
- R6: Consecutive AUTO REFRESH commands are T_RC cycles apart, with NOP in between. own_o falls T_RC cycles after the last AUTO REFRESH. Outside ownership cmd_o is NOP.
- R7: An event issues pending-count × BURST AUTO REFRESH commands, using the pending count at the rising edge where the grant is taken.
- R8: An expiry that occurs during an event, or at the same edge as the grant, is kept as pending for the next event. req_o is then high in the first cycle after the release.
- R9: The pending count saturates at 2^PEND_W−1; further expiries are lost.
- R10: grant_i is ignored while req_o is low; own_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_done_i | input | 1 | Memory power-up sequence complete; enables the interval counter |
| grant_i | input | 1 | Access sequencer idle and handing over the bus |
| req_o | output | 1 | Refresh request |
| own_o | output | 1 | Scheduler owns the command bus |
| cmd_o | output | 3 | Command {ras_n, cas_n, we_n}: NOP 111, PRECHARGE 010, AUTO REFRESH 001 |
| a10_o | output | 1 | Address bit 10 drive (all-bank precharge) |
| ba_o | output | 2 | Bank address drive |

## Verification
An interval expiry and the grant hand-over can fall on the same rising edge. Both then write the pending count: the grant clears it and the expiry adds one. The bench provokes this by watching its own model's interval count and raising grant_i in the cycle before the expiry edge. It also holds grant_i low across several intervals, so that expiries land while a long event is still running. The per-cycle model predicts a pending count of one after such a collision, so req_o is judged in the first cycle after release. The length of the next event is judged as well.

// File: rtl/sdram_ref_pkg.sv
package sdram_ref_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'b111,
    CMD_PRE = 3'b010,
    CMD_REF = 3'b001
  } sdram_cmd_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_PRE,
    S_WAIT,
    S_REF
  } ref_state_e;
endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int unsigned INTERVAL = 1021
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(INTERVAL + 1);
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!en_i)    cnt_q <= '0;
    else if (tick_o)   cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ref_pending_ctr.sv
module ref_pending_ctr #(
  parameter int unsigned PEND_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              take_i,
  output logic [PEND_W-1:0] pend_o,
  output logic              nz_o
);
  localparam logic [PEND_W-1:0] PMAX = {PEND_W{1'b1}};

  logic [PEND_W-1:0] pend_q, base, pend_d;

  // take clears; a same-edge tick survives into the next event
  always_comb begin
    base   = take_i ? '0 : pend_q;
    pend_d = (tick_i && base != PMAX) ? base + 1'b1 : base;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;
  assign nz_o   = (pend_q != '0);
endmodule

// File: rtl/ref_cmd_seq.sv
module ref_cmd_seq
  import sdram_ref_pkg::*;
#(
  parameter int unsigned T_RP   = 2,
  parameter int unsigned T_RC   = 8,
  parameter int unsigned LEFT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEFT_W-1:0] count_i,
  output logic              idle_o,
  output logic [2:0]        cmd_o,
  output logic              a10_o
);
  localparam int unsigned TMAX  = (T_RC > T_RP) ? T_RC : T_RP;
  localparam int unsigned TMR_W = (TMAX > 2) ? $clog2(TMAX) : 1;
  localparam logic [TMR_W-1:0] RP_LOAD = TMR_W'(T_RP - 2);
  localparam logic [TMR_W-1:0] RC_LOAD = TMR_W'(T_RC - 2);

  ref_state_e        state_q;
  logic [TMR_W-1:0]  tmr_q;
  logic [LEFT_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      tmr_q   <= '0;
      left_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_PRE;
          left_q  <= count_i;
        end
        S_PRE: begin
          state_q <= S_WAIT;
          tmr_q   <= RP_LOAD;
        end
        S_WAIT: begin
          if (tmr_q == '0) state_q <= (left_q != '0) ? S_REF : S_IDLE;
          else             tmr_q   <= tmr_q - 1'b1;
        end
        S_REF: begin
          left_q  <= left_q - 1'b1;
          state_q <= S_WAIT;
          tmr_q   <= RC_LOAD;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      S_PRE:   cmd_o = CMD_PRE;
      S_REF:   cmd_o = CMD_REF;
      default: cmd_o = CMD_NOP;
    endcase
  end

  assign a10_o  = (state_q == S_PRE);
  assign idle_o = (state_q == S_IDLE);
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
  parameter int unsigned CLK_MHZ       = 133,
  parameter int unsigned REF_PERIOD_NS = 7800,
  parameter int unsigned MARGIN_CYC    = 16,
  parameter int unsigned T_RP          = 2,
  parameter int unsigned T_RC          = 8,
  parameter int unsigned BURST         = 1,
  parameter int unsigned PEND_W        = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       init_done_i,
  input  logic       grant_i,
  output logic       req_o,
  output logic       own_o,
  output logic [2:0] cmd_o,
  output logic       a10_o,
  output logic [1:0] ba_o
);
  localparam int unsigned INTERVAL_CYC = CLK_MHZ * REF_PERIOD_NS / 1000 - MARGIN_CYC;
  localparam int unsigned LEFT_W       = PEND_W + $clog2(BURST + 1);

  logic              tick, take, pend_nz, idle;
  logic [PEND_W-1:0] pend;
  logic [LEFT_W-1:0] count;

  ref_interval_timer #(.INTERVAL(INTERVAL_CYC)) i_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (init_done_i),
    .tick_o(tick)
  );

  ref_pending_ctr #(.PEND_W(PEND_W)) i_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .take_i(take),
    .pend_o(pend),
    .nz_o  (pend_nz)
  );

  generate
    if (BURST > 1) begin : g_mul
      assign count = LEFT_W'(pend) * LEFT_W'(BURST);
    end else begin : g_one
      assign count = LEFT_W'(pend);
    end
  endgenerate

  ref_cmd_seq #(.T_RP(T_RP), .T_RC(T_RC), .LEFT_W(LEFT_W)) i_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(take),
    .count_i(count),
    .idle_o (idle),
    .cmd_o  (cmd_o),
    .a10_o  (a10_o)
  );

  assign req_o = pend_nz && idle;
  assign take  = req_o && grant_i;
  assign own_o = !idle;
  assign ba_o  = 2'b00;
endmodule

// File: rtl/sdram_refresh_sched_chk.sv
module sdram_refresh_sched_chk
  import sdram_ref_pkg::*;
#(
  parameter int unsigned T_RP = 2,
  parameter int unsigned T_RC = 8
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       grant_i,
  input logic       req_o,
  input logic       own_o,
  input logic [2:0] cmd_o,
  input logic       a10_o
);
  logic [7:0] gap_q;
  logic [2:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= 8'hff;
      last_q <= CMD_NOP;
    end else if (cmd_o != CMD_NOP) begin
      gap_q  <= 8'd1;
      last_q <= cmd_o;
    end else if (gap_q != 8'hff) begin
      gap_q  <= gap_q + 8'd1;
    end
  end

  // R4
  grant_pre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && grant_i) |=> (own_o && cmd_o == CMD_PRE && a10_o));

  // R3
  req_own_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_o && own_o));

  // R4
  a10_pre_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a10_o |-> (cmd_o == CMD_PRE));

  // R5
  ref_after_pre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_REF && last_q == CMD_PRE) |-> (gap_q == 8'(T_RP)));

  // R6
  ref_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_REF && last_q == CMD_REF) |-> (gap_q == 8'(T_RC)));

  // R6
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(own_o) |-> (last_q == CMD_REF && gap_q == 8'(T_RC)));

  // R6
  idle_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !own_o |-> (cmd_o == CMD_NOP));
endmodule

bind sdram_refresh_sched sdram_refresh_sched_chk #(.T_RP(T_RP), .T_RC(T_RC)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .grant_i(grant_i),
  .req_o  (req_o),
  .own_o  (own_o),
  .cmd_o  (cmd_o),
  .a10_o  (a10_o)
);

// File: tb/test_sdram_refresh_sched.sv
module test_sdram_refresh_sched;
  localparam int INTERVAL = 24;  // 250 MHz * 160 ns / 1000 - 16
  localparam int T_RP = 2;
  localparam int T_RC = 8;
  localparam int BURST = 2;
  localparam int PEND_W = 3;
  localparam int PMAX = (1 << PEND_W) - 1;
  localparam logic [2:0] NOP = 3'b111, PRE = 3'b010, REF = 3'b001;

  logic clk = 0, rst_n = 0, init_done = 0, grant = 0;
  logic req, own, a10;
  logic [2:0] cmd;
  logic [1:0] ba;

  always #2 clk = ~clk;

  sdram_refresh_sched #(
    .CLK_MHZ(250), .REF_PERIOD_NS(160), .MARGIN_CYC(16),
    .T_RP(T_RP), .T_RC(T_RC), .BURST(BURST), .PEND_W(PEND_W)
  ) i_sdram_refresh_sched (
    .clk_i(clk), .rst_ni(rst_n), .init_done_i(init_done), .grant_i(grant),
    .req_o(req), .own_o(own), .cmd_o(cmd), .a10_o(a10), .ba_o(ba)
  );

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_icnt = 0, m_pend = 0;
  logic [2:0] m_q[$];
  int exp_refs[$];

  function automatic bit m_req();
    return (m_pend > 0) && (m_q.size() == 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_icnt = 0; m_pend = 0; m_q.delete();
    end else begin
      bit take, tick;
      take = m_req() && grant;
      tick = 0;
      if (m_q.size() > 0) void'(m_q.pop_front());
      if (!init_done) m_icnt = 0;
      else if (m_icnt == INTERVAL - 1) begin m_icnt = 0; tick = 1; end
      else m_icnt++;
      if (take) begin
        int n;
        n = m_pend * BURST;
        exp_refs.push_back(n);
        m_q.push_back(PRE);
        for (int i = 1; i < T_RP; i++) m_q.push_back(NOP);
        for (int r = 0; r < n; r++) begin
          m_q.push_back(REF);
          for (int i = 1; i < T_RC; i++) m_q.push_back(NOP);
        end
        m_pend = 0;
      end
      if (tick && m_pend < PMAX) m_pend++;
    end
  end

  // per-cycle comparison
  bit prev_own = 0;
  int ref_cnt = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [2:0] ecmd;
      ecmd = (m_q.size() > 0) ? m_q[0] : NOP;
      chk(req == m_req(), "R3 req_o", int'(req), int'(m_req()));
      chk(own == (m_q.size() > 0), "R6 own_o", int'(own), int'(m_q.size() > 0));
      chk(cmd == ecmd, "R5 cmd_o", int'(cmd), int'(ecmd));
      chk(a10 == (ecmd == PRE), "R4 a10_o", int'(a10), int'(ecmd == PRE));
      chk(ba == 2'b00, "R4 ba_o", int'(ba), 0);
      if (own && cmd == REF) ref_cnt++;
      if (prev_own && !own) begin
        int e;
        e = (exp_refs.size() > 0) ? exp_refs.pop_front() : -1;
        chk(ref_cnt == e, "R7 refresh count", ref_cnt, e);
        ref_cnt = 0;
      end
      prev_own = own;
    end
  end

  task automatic summary();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      chk(0, "watchdog", cycles, 150000);
      summary();
    end
  end

  task automatic nc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_release();
    @(negedge clk);
    while (own) @(negedge clk);
  endtask

  initial begin
    nc(3);
    chk(req == 0 && own == 0, "R1 req/own in reset", int'({req, own}), 0);
    chk(cmd == NOP && a10 == 0 && ba == 0, "R1 cmd/a10/ba in reset", int'(cmd), int'(NOP));
    rst_n = 1;
    // R2 and R10: long wait with init low, grant pulsed with no request
    grant = 1;
    nc(60);
    chk(req == 0 && own == 0, "R2/R10 no request while init low", int'({req, own}), 0);
    grant = 0;
    init_done = 1;
    nc(INTERVAL - 1);
    chk(req == 0, "R2 no request before first expiry", int'(req), 0);
    nc(1);
    chk(req == 1, "R2 request after first expiry", int'(req), 1);
    nc(5);
    chk(req == 1, "R3 request held without grant", int'(req), 1);
    // immediate service over several intervals
    grant = 1;
    nc(3 * INTERVAL);
    // accumulate three expiries, one long event with expiries inside it
    grant = 0;
    wait_release();
    nc(3 * INTERVAL);
    chk(req == 1, "R3 request pending", int'(req), 1);
    grant = 1;
    nc(1);
    grant = 0;
    wait_release();
    nc(2 * INTERVAL);
    // R8: grant taken on the same edge as an expiry
    while (!(m_icnt == INTERVAL - 1 && m_req())) @(negedge clk);
    grant = 1;
    nc(1);
    grant = 0;
    chk(own == 1 && m_pend == 1, "R8 collision taken, one held", int'(own), 1);
    wait_release();
    chk(req == 1, "R8 request right after release", int'(req), 1);
    // R9: saturation
    nc(PMAX * INTERVAL + 3 * INTERVAL);
    chk(req == 1, "R9 request while saturated", int'(req), 1);
    grant = 1;
    nc(1);
    grant = 0;
    chk(own == 1 && exp_refs.size() > 0 && exp_refs[0] == PMAX * BURST,
        "R9 saturated event length", exp_refs.size() > 0 ? exp_refs[0] : -1, PMAX * BURST);
    wait_release();
    // R10: grant with no request
    while (!(m_pend == 0 && !own)) begin
      grant = 1; nc(1); grant = 0;
      wait_release();
    end
    grant = 1;
    nc(1);
    chk(own == 0, "R10 grant without request ignored", int'(own), 0);
    grant = 0;
    nc(2 * INTERVAL);
    summary();
  end
endmodule